// File: doc/BRIEF.md
# Reset Sequencer with Clock Monitor

This block produces the system reset and records why it happened. It merges four reset sources: power-on, an active-low open-drain reset pin that other devices can pull, a watchdog timeout strobe, and a clock-loss detector watching the oscillator. Everything runs on a free-running reference clock. The oscillator is sampled as data in that domain, and it is declared lost when no rising edge arrives within a programmable number of reference cycles.

For an internal reset (watchdog or clock loss), the sequencer pulls the pin low for a fixed time. It then releases the pin, waits a settle time and samples the pin. A pin that is still low means another device is holding reset, so the cause is reported as external. If self-clock fallback is enabled, a lost clock does not reset the system. The block instead enters self-clock mode, sets a status bit and a sticky flag, and leaves that mode after a set number of oscillator edges once the clock comes back.

The reset controller has five states. `RS_POR` counts the power-on hold and goes to `RS_RUN` when the count expires. `RS_RUN` goes to `RS_EXT_HOLD` on a qualified low pin, and otherwise to `RS_DRIVE` on a clock-loss request or a watchdog strobe. `RS_DRIVE` goes to `RS_SETTLE` when the drive count expires. `RS_SETTLE` goes to `RS_RUN` if the pin is high, or to `RS_EXT_HOLD` if it is low. `RS_EXT_HOLD` goes to `RS_RUN` when the pin rises. The self-clock controller has three states. `SC_NORMAL` goes to `SC_SELF` on clock loss when both enables are set. `SC_SELF` goes to `SC_RECOVER` on the first returning edge. `SC_RECOVER` goes to `SC_NORMAL` when the edge count completes, or back to `SC_SELF` if the clock is lost again.

Top module: `rst_clkmon_seq`

## Requirements
- R1: After `por_n` is released, `sys_rst` stays high for exactly POR_CYCLES reference cycles. `pin_pull` stays low during this time. The cause then reads 4'b0001 (bit 0 = power-on).
- R2: A watchdog strobe sampled in the running state raises `pin_pull` on the next cycle and holds it for exactly PIN_DRIVE cycles. `sys_rst` is high throughout.
- R3: After the drive phase, the pin is released and `sys_rst` stays high for PIN_SETTLE more cycles. If the pin is then high, `sys_rst` falls and the cause shows the internal source: 4'b0100 (bit 2) for watchdog, 4'b1000 (bit 3) for clock monitor.
- R4: If the pin is still low at the end of the settle phase, `sys_rst` stays high until the pin goes high. The cause then reads 4'b0010 (bit 1 = external).
- R5: In the running state, a pin low for two or more synchronised samples starts an external reset. A single-cycle low pulse is ignored: `sys_rst` stays low and the cause is unchanged.
- R6: An external reset never drives the pin and adds no power-on delay. `sys_rst` falls three cycles after the pin returns high, through a two-flop synchroniser.
- R7: With `mon_en`=1 and `scm_en`=0, the absence of an oscillator rising edge for `loss_limit` reference cycles triggers the drive and settle sequence with the clock-monitor cause. A clock-monitor request takes precedence over a watchdog strobe in the same cycle.
- R8: With `mon_en`=0, a stopped oscillator causes no reset, no pin drive and no self-clock mode.
- R9: With `mon_en`=1 and `scm_en`=1, clock loss sets `scm_active` and `scm_flag` without any reset or pin drive.
- R10: In self-clock mode, `scm_active` clears on the RECOVER_EDGES-th synchronised oscillator rising edge after the clock returns. `scm_flag` stays set until power-on.
- R11: The cause is one-hot and changes only in the cycle where `sys_rst` falls. A power-on reset reports 4'b0001 even if the pin is held low, and it clears `scm_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous assert |
| osc_clk | input | 1 | Monitored oscillator, sampled as data |
| pin_in | input | 1 | Level of the open-drain reset pin (0 = asserted) |
| wdog_tmo | input | 1 | Watchdog timeout strobe |
| mon_en | input | 1 | Clock monitor enable |
| scm_en | input | 1 | Self-clock fallback enable |
| loss_limit | input | LOSS_W | Reference cycles without an oscillator edge before loss is declared (nonzero) |
| pin_pull | output | 1 | Pull the reset pin low |
| sys_rst | output | 1 | Internal reset, active high |
| rst_cause | output | 4 | One-hot cause: bit0 power-on, bit1 external, bit2 watchdog, bit3 clock monitor |
| scm_active | output | 1 | Self-clock mode in progress |
| scm_flag | output | 1 | Sticky record of self-clock entry |

## Verification
A watchdog strobe raises `pin_pull` one cycle after it is sampled. The pin then falls PIN_DRIVE cycles later, and `sys_rst` falls PIN_SETTLE cycles after that. For an external reset, `sys_rst` rises three cycles after the pin is qualified low and falls three cycles after the pin returns high. The bench advances one clock at a time and samples one time unit after each edge, so each of these results is checked on its exact cycle and also one cycle before it. Clock-loss and self-clock events depend on an asynchronous oscillator, so those checks poll within bounded windows. For recovery, the bench counts the oscillator edges it generates and samples four cycles after the last one, which is past the synchroniser latency and before the next edge.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
    typedef enum logic [2:0] {
        RS_POR, RS_RUN, RS_DRIVE, RS_SETTLE, RS_EXT_HOLD
    } rs_state_t;

    typedef enum logic [1:0] {
        SC_NORMAL, SC_SELF, SC_RECOVER
    } sc_state_t;

    localparam int CAUSE_W = 4;
    localparam logic [1:0] C_POR    = 2'd0;
    localparam logic [1:0] C_EXT    = 2'd1;
    localparam logic [1:0] C_WDOG   = 2'd2;
    localparam logic [1:0] C_CLKMON = 2'd3;
endpackage

// File: rtl/osc_watch.sv
module osc_watch #(
    parameter int LOSS_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_in,
    input  logic [LOSS_W-1:0] loss_limit,
    output logic              osc_edge,
    output logic              osc_lost
);
    logic [2:0]        sh;
    logic [LOSS_W-1:0] gap;

    // two synchroniser flops plus one history flop for the edge detector
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[1:0], osc_in};
    end

    assign osc_edge = sh[1] & ~sh[2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            gap <= '0;
        else if (osc_edge)     gap <= '0;
        else if (gap != '1)    gap <= gap + 1'b1;
    end

    assign osc_lost = (gap >= loss_limit);

    // R7: an observed edge always ends a loss indication on the next cycle
    p_edge_ends_loss_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_edge && loss_limit != '0) |=> (!osc_lost || loss_limit == '0));
endmodule

// File: rtl/scm_ctrl.sv
module scm_ctrl
    import rstseq_pkg::*;
#(
    parameter int RECOVER_EDGES = 8192
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_edge,
    input  logic osc_lost,
    input  logic mon_en,
    input  logic scm_en,
    output logic scm_active,
    output logic scm_flag,
    output logic cm_req
);
    localparam int RW = $clog2(RECOVER_EDGES + 1);

    sc_state_t      state, nstate;
    logic [RW-1:0]  rcnt;

    always_comb begin
        nstate = state;
        unique case (state)
            SC_NORMAL:  if (osc_lost && mon_en && scm_en) nstate = SC_SELF;
            SC_SELF:    if (osc_edge) nstate = SC_RECOVER;
            SC_RECOVER: begin
                if (osc_lost)
                    nstate = SC_SELF;
                else if (osc_edge && rcnt == RW'(RECOVER_EDGES - 1))
                    nstate = SC_NORMAL;
            end
            default:    nstate = SC_NORMAL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= SC_NORMAL;
            rcnt     <= '0;
            scm_flag <= 1'b0;
        end else begin
            state <= nstate;
            if (state == SC_SELF && osc_edge)
                rcnt <= RW'(1);
            else if (state == SC_RECOVER && osc_edge)
                rcnt <= rcnt + 1'b1;
            if (state == SC_NORMAL && nstate == SC_SELF)
                scm_flag <= 1'b1;
        end
    end

    always_comb begin
        scm_active = (state != SC_NORMAL);
        cm_req     = (state == SC_NORMAL) && osc_lost && mon_en && !scm_en;
    end

    // R9: entering self-clock mode always leaves the sticky flag set
    p_enter_sets_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scm_active) |-> scm_flag);
    // R10: the flag is sticky until power-on
    p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        scm_flag |=> scm_flag);
endmodule

// File: rtl/rst_fsm.sv
module rst_fsm
    import rstseq_pkg::*;
#(
    parameter int POR_CYCLES = 8192,
    parameter int PIN_DRIVE  = 64,
    parameter int PIN_SETTLE = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pin_in,
    input  logic               wdog_tmo,
    input  logic               cm_req,
    input  logic               mon_en,
    output logic               pin_pull,
    output logic               sys_rst,
    output logic [CAUSE_W-1:0] cause
);
    localparam int MAXC  = (POR_CYCLES > PIN_DRIVE) ?
                           ((POR_CYCLES > PIN_SETTLE) ? POR_CYCLES : PIN_SETTLE) :
                           ((PIN_DRIVE > PIN_SETTLE) ? PIN_DRIVE : PIN_SETTLE);
    localparam int CNT_W = $clog2(MAXC + 1);

    rs_state_t        state, nstate;
    logic [CNT_W-1:0] cnt, lim;
    logic [1:0]       pend, npend, lidx;
    logic             load, done;
    logic [1:0]       ps;
    logic             pin_s, pin_d, ext_req;

    // pin synchroniser; idle level is high (pulled up)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ps    <= 2'b11;
            pin_d <= 1'b1;
        end else begin
            ps    <= {ps[0], pin_in};
            pin_d <= ps[1];
        end
    end
    assign pin_s   = ps[1];
    assign ext_req = ~pin_s & ~pin_d;

    always_comb begin
        unique case (state)
            RS_POR:    lim = CNT_W'(POR_CYCLES - 1);
            RS_DRIVE:  lim = CNT_W'(PIN_DRIVE - 1);
            RS_SETTLE: lim = CNT_W'(PIN_SETTLE - 1);
            default:   lim = '0;
        endcase
    end
    assign done = (cnt == lim);

    always_comb begin
        nstate = state;
        npend  = pend;
        load   = 1'b0;
        lidx   = pend;
        unique case (state)
            RS_POR: if (done) begin
                nstate = RS_RUN;
                load   = 1'b1;
                lidx   = C_POR;
            end
            RS_RUN: begin
                if (ext_req) begin
                    nstate = RS_EXT_HOLD;
                end else if (cm_req) begin
                    nstate = RS_DRIVE;
                    npend  = C_CLKMON;
                end else if (wdog_tmo) begin
                    nstate = RS_DRIVE;
                    npend  = C_WDOG;
                end
            end
            RS_DRIVE:  if (done) nstate = RS_SETTLE;
            RS_SETTLE: if (done) begin
                if (pin_s) begin
                    nstate = RS_RUN;
                    load   = 1'b1;
                    lidx   = pend;
                end else begin
                    nstate = RS_EXT_HOLD;
                end
            end
            RS_EXT_HOLD: if (pin_s) begin
                nstate = RS_RUN;
                load   = 1'b1;
                lidx   = C_EXT;
            end
            default: nstate = RS_POR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RS_POR;
            cnt   <= '0;
            pend  <= C_WDOG;
            cause <= '0;
        end else begin
            state <= nstate;
            pend  <= npend;
            if (nstate != state)
                cnt <= '0;
            else if (state == RS_POR || state == RS_DRIVE || state == RS_SETTLE)
                cnt <= cnt + 1'b1;
            if (load) begin
                cause       <= '0;
                cause[lidx] <= 1'b1;
            end
        end
    end

    always_comb begin
        sys_rst  = (state != RS_RUN);
        pin_pull = (state == RS_DRIVE);
    end

    // R2: the pin is only pulled while internal reset is active
    p_pull_in_rst_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pin_pull |-> sys_rst);
    // R2: the drive phase ends only after its full count
    p_drive_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pin_pull) |-> ($past(cnt) == CNT_W'(PIN_DRIVE - 1)));
    // R11: the cause changes only when reset is released
    p_cause_at_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cause) |-> $fell(sys_rst));
    // R8: a clock-monitor sequence starts only with the monitor enabled
    p_cm_needs_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pin_pull) && pend == C_CLKMON) |-> $past(mon_en));
endmodule

// File: rtl/rst_clkmon_seq.sv
module rst_clkmon_seq
    import rstseq_pkg::*;
#(
    parameter int POR_CYCLES    = 8192,
    parameter int PIN_DRIVE     = 64,
    parameter int PIN_SETTLE    = 32,
    parameter int RECOVER_EDGES = 8192,
    parameter int LOSS_W        = 16
) (
    input  logic               ref_clk,
    input  logic               por_n,
    input  logic               osc_clk,
    input  logic               pin_in,
    input  logic               wdog_tmo,
    input  logic               mon_en,
    input  logic               scm_en,
    input  logic [LOSS_W-1:0]  loss_limit,
    output logic               pin_pull,
    output logic               sys_rst,
    output logic [CAUSE_W-1:0] rst_cause,
    output logic               scm_active,
    output logic               scm_flag
);
    logic osc_edge, osc_lost, cm_req;

    osc_watch #(.LOSS_W(LOSS_W)) u_watch (
        .clk        (ref_clk),
        .rst_n      (por_n),
        .osc_in     (osc_clk),
        .loss_limit (loss_limit),
        .osc_edge   (osc_edge),
        .osc_lost   (osc_lost)
    );

    scm_ctrl #(.RECOVER_EDGES(RECOVER_EDGES)) u_scm (
        .clk        (ref_clk),
        .rst_n      (por_n),
        .osc_edge   (osc_edge),
        .osc_lost   (osc_lost),
        .mon_en     (mon_en),
        .scm_en     (scm_en),
        .scm_active (scm_active),
        .scm_flag   (scm_flag),
        .cm_req     (cm_req)
    );

    rst_fsm #(
        .POR_CYCLES (POR_CYCLES),
        .PIN_DRIVE  (PIN_DRIVE),
        .PIN_SETTLE (PIN_SETTLE)
    ) u_fsm (
        .clk      (ref_clk),
        .rst_n    (por_n),
        .pin_in   (pin_in),
        .wdog_tmo (wdog_tmo),
        .cm_req   (cm_req),
        .mon_en   (mon_en),
        .pin_pull (pin_pull),
        .sys_rst  (sys_rst),
        .cause    (rst_cause)
    );

    // R9: self-clock mode never coincides with a pulled pin
    p_scm_no_pull_r9: assert property (@(posedge ref_clk) disable iff (!por_n)
        $rose(scm_active) |-> !$rose(pin_pull));
endmodule

// File: tb/rst_clkmon_seq_tb.sv
`timescale 1ns/1ps
module rst_clkmon_seq_tb;
    localparam int POR = 64;
    localparam int DRV = 16;
    localparam int STL = 8;
    localparam int REC = 16;
    localparam int LW  = 8;

    localparam logic [3:0] K_POR = 4'b0001;
    localparam logic [3:0] K_EXT = 4'b0010;
    localparam logic [3:0] K_WDG = 4'b0100;
    localparam logic [3:0] K_CM  = 4'b1000;

    logic          ref_clk = 1'b0;
    logic          por_n = 1'b0;
    logic          osc_clk;
    logic          ext_low = 1'b0;
    logic          wdog_tmo = 1'b0;
    logic          mon_en = 1'b0;
    logic          scm_en = 1'b0;
    logic [LW-1:0] loss_limit = LW'(20);
    logic          pin_pull, sys_rst, scm_active, scm_flag;
    logic [3:0]    rst_cause;
    wire           pin_in = ~(ext_low | pin_pull);

    logic osc_run = 1'b1;
    int   rises = 0;
    int   checks = 0;
    int   errors = 0;
    logic [3:0] exp_c;

    rst_clkmon_seq #(
        .POR_CYCLES(POR), .PIN_DRIVE(DRV), .PIN_SETTLE(STL),
        .RECOVER_EDGES(REC), .LOSS_W(LW)
    ) u_dut (
        .ref_clk(ref_clk), .por_n(por_n), .osc_clk(osc_clk), .pin_in(pin_in),
        .wdog_tmo(wdog_tmo), .mon_en(mon_en), .scm_en(scm_en),
        .loss_limit(loss_limit), .pin_pull(pin_pull), .sys_rst(sys_rst),
        .rst_cause(rst_cause), .scm_active(scm_active), .scm_flag(scm_flag)
    );

    always #4 ref_clk = ~ref_clk;

    initial begin
        osc_clk = 1'b0;
        forever begin
            repeat (3) @(posedge ref_clk);
            #2;
            if (osc_run) begin
                osc_clk = ~osc_clk;
                if (osc_clk) rises++;
            end
        end
    end

    function automatic logic [3:0] cause_code(input int kind);
        return 4'(1 << kind);
    endfunction

    // model: 0 watchdog, 1 external pulse of width w, 2 idle
    function automatic logic [3:0] next_cause(input logic [3:0] cur, input int ev, input int w);
        if (ev == 0) return cause_code(2);
        if (ev == 1 && w >= 2) return cause_code(1);
        return cur;
    endfunction

    task automatic step();
        @(posedge ref_clk);
        #1;
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wait_rises(input int target);
        for (int i = 0; i < 4000 && rises < target; i++) step();
    endtask

    task automatic wait_release(input int lim);
        for (int i = 0; i < lim && sys_rst; i++) step();
    endtask

    initial begin
        repeat (400000) @(posedge ref_clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int base, w, ev;
        logic seen_rst, seen_pull, seen_scm;
        void'($urandom(32'h1c3a_77e5));

        steps(3);
        chk("R1 reset state sys_rst", sys_rst, 1);
        chk("R1 reset state pin_pull", pin_pull, 0);
        chk("R11 reset state cause", rst_cause, 0);
        chk("R9 reset state scm", {scm_active, scm_flag}, 0);

        // R1: power-on hold length
        por_n = 1'b1;
        steps(POR - 1);
        chk("R1 still in reset at POR-1", sys_rst, 1);
        chk("R1 pin not driven", pin_pull, 0);
        step();
        chk("R1 released at POR", sys_rst, 0);
        chk("R1 cause power-on", rst_cause, K_POR);
        exp_c = K_POR;

        // R2/R3: watchdog drive and settle timing
        steps(5);
        wdog_tmo = 1'b1;
        step();
        wdog_tmo = 1'b0;
        chk("R2 pin pulled after strobe", pin_pull, 1);
        chk("R2 reset active", sys_rst, 1);
        steps(DRV - 1);
        chk("R2 pin pulled at end of drive", pin_pull, 1);
        step();
        chk("R2 pin released after drive", pin_pull, 0);
        steps(STL - 1);
        chk("R3 reset during settle", sys_rst, 1);
        chk("R3 cause held during settle", rst_cause, K_POR);
        step();
        chk("R3 reset released", sys_rst, 0);
        chk("R3 cause watchdog", rst_cause, K_WDG);
        exp_c = K_WDG;

        // R6: external reset timing, no pin drive
        steps(4);
        ext_low = 1'b1;
        steps(4);
        chk("R6 external reset active", sys_rst, 1);
        chk("R6 pin not driven by block", pin_pull, 0);
        steps(6);
        ext_low = 1'b0;
        steps(2);
        chk("R6 still in reset 2 after high", sys_rst, 1);
        step();
        chk("R6 released 3 after high", sys_rst, 0);
        chk("R6 cause external", rst_cause, K_EXT);
        exp_c = K_EXT;

        // R5: one-cycle glitch ignored
        steps(4);
        wdog_tmo = 1'b0;
        ext_low = 1'b1;
        step();
        ext_low = 1'b0;
        seen_rst = 1'b0;
        for (int i = 0; i < 10; i++) begin step(); seen_rst |= sys_rst; end
        chk("R5 glitch ignored", seen_rst, 0);
        chk("R5 cause unchanged", rst_cause, K_EXT);

        // R4: pin held low through settle becomes external
        wdog_tmo = 1'b1;
        step();
        wdog_tmo = 1'b0;
        steps(3);
        ext_low = 1'b1;
        steps(DRV + STL + 6);
        chk("R4 held in reset while pin low", sys_rst, 1);
        ext_low = 1'b0;
        wait_release(10);
        chk("R4 released", sys_rst, 0);
        chk("R4 cause external", rst_cause, K_EXT);
        exp_c = K_EXT;

        // R8: monitor disabled, stopped clock has no effect
        steps(4);
        mon_en = 1'b0;
        scm_en = 1'b0;
        osc_run = 1'b0;
        seen_rst = 1'b0; seen_pull = 1'b0; seen_scm = 1'b0;
        for (int i = 0; i < 80; i++) begin
            step();
            seen_rst |= sys_rst; seen_pull |= pin_pull; seen_scm |= scm_active;
        end
        chk("R8 no reset with monitor off", {seen_rst, seen_pull, seen_scm}, 0);
        chk("R8 cause unchanged", rst_cause, K_EXT);
        osc_run = 1'b1;
        steps(12);

        // R7: clock loss reset
        mon_en = 1'b1;
        steps(4);
        osc_run = 1'b0;
        seen_pull = 1'b0;
        for (int i = 0; i < 60 && !pin_pull; i++) step();
        seen_pull = pin_pull;
        chk("R7 pin pulled on clock loss", seen_pull, 1);
        osc_run = 1'b1;
        wait_release(DRV + STL + 20);
        chk("R7 reset released", sys_rst, 0);
        chk("R7 cause clock monitor", rst_cause, K_CM);
        exp_c = K_CM;
        chk("R7 no self-clock mode", scm_active, 0);

        // R9/R10: self-clock fallback
        steps(10);
        scm_en = 1'b1;
        steps(2);
        osc_run = 1'b0;
        seen_rst = 1'b0; seen_pull = 1'b0;
        for (int i = 0; i < 40; i++) begin
            step();
            seen_rst |= sys_rst; seen_pull |= pin_pull;
        end
        chk("R9 scm active", scm_active, 1);
        chk("R9 scm flag", scm_flag, 1);
        chk("R9 no reset in fallback", {seen_rst, seen_pull}, 0);
        base = rises;
        osc_run = 1'b1;
        wait_rises(base + REC - 1);
        steps(4);
        chk("R10 still active before last edge", scm_active, 1);
        wait_rises(base + REC);
        steps(4);
        chk("R10 cleared after recover edges", scm_active, 0);
        chk("R10 flag sticky", scm_flag, 1);

        // randomised watchdog / external pulse mix
        for (int n = 0; n < 30; n++) begin
            ev = int'($urandom % 3);
            w  = 1 + int'($urandom % 4);
            seen_rst = 1'b0;
            if (ev == 0) begin
                wdog_tmo = 1'b1; step(); wdog_tmo = 1'b0;
            end else if (ev == 1) begin
                ext_low = 1'b1; steps(w); ext_low = 1'b0;
            end
            for (int i = 0; i < DRV + STL + 12; i++) begin step(); seen_rst |= sys_rst; end
            exp_c = next_cause(exp_c, ev, w);
            chk("R5 random cause", rst_cause, exp_c);
            chk("R3 random released", sys_rst, 0);
            if (ev == 1 && w == 1) chk("R5 random glitch no reset", seen_rst, 0);
        end

        // R11: power-on overrides, pin held low
        ext_low = 1'b1;
        por_n = 1'b0;
        steps(3);
        chk("R11 flag cleared by power-on", scm_flag, 0);
        por_n = 1'b1;
        steps(POR);
        chk("R11 cause power-on despite pin", rst_cause, K_POR);
        chk("R11 released at POR", sys_rst, 0);
        steps(3);
        ext_low = 1'b0;
        wait_release(10);
        chk("R11 later external cause", rst_cause, K_EXT);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule